// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

A free-running up-counter that drives three compare output pins, called A, B and C. A 4-bit waveform mode input picks how the counter sequences and where its wrap value (TOP) comes from. The choices are a plain 16-bit rollover, clear-on-compare with TOP taken from compare value A, and single-slope fast PWM. Fast PWM has three fixed TOP values, plus one TOP taken from a separate input and one taken from compare value A. Each channel has its own 2-bit output code that selects toggle, clear, set, non-inverting PWM or inverting PWM, or leaves the pin disconnected.

The compare values and the external TOP are direct inputs and are used as presented. Each pin comes with a drive-enable flag that tells the pad logic whether the timer owns the pin. A single force-off input takes all three pins away from the timer at once. Each channel keeps its waveform level while it is disconnected, so reconnecting it resumes from the level it had. The counter advances only while the count enable is high. One-cycle strobes report the counter wrap and each channel's compare match.

Top module: `cwt_timer`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, with the count enable low, `wave_o`, `wave_oe_o`, `ovf_o` and `match_o` are all zero, and the counter starts at 0.
- R2: On each clock edge with `cnt_en_i` high, the counter advances by one, or returns to 0 when it equals TOP. At that return `ovf_o` is high for exactly the following cycle. With `cnt_en_i` low, the counter, the pins and the strobes do not move.
- R3: `wave_mode_i` sets TOP as follows: 4 gives TOP = `cmp_a_i` (non-PWM); 5, 6 and 7 give TOP = 0x00FF, 0x01FF and 0x03FF (fast PWM); 14 gives TOP = `top_ext_i` (fast PWM); 15 gives TOP = `cmp_a_i` (fast PWM). Code 0 and every code not listed give non-PWM counting with TOP = 0xFFFF.
- R4: `match_o` bit 0 belongs to channel A, bit 1 to B and bit 2 to C. A bit is high for one cycle after an enabled edge at which the counter equalled that channel's compare value. Any pin change caused by that match appears in the same cycle as the strobe.
- R5: In non-PWM modes, output code 2'b00 disconnects the channel, 2'b01 toggles its pin on a match, 2'b10 drives the pin low on a match and 2'b11 drives it high on a match. Codes 01, 10 and 11 raise the channel's `wave_oe_o` bit.
- R6: In fast PWM, code 2'b10 drives the pin low on a match and high at the wrap to 0 (non-inverting). Code 2'b11 drives the pin high on a match and low at the wrap (inverting). Both codes raise the channel's drive enable.
- R7: In fast PWM, code 2'b01 toggles channel A on a match only in waveform modes 14 and 15. Channels B and C with code 01 are disconnected. In fast PWM modes 5, 6 and 7, code 01 disconnects every channel.
- R8: In fast PWM with an output code whose upper bit is 1, a compare value equal to TOP causes no action at the match. Only the set or clear action at the wrap is applied.
- R9: A disconnected channel drives `wave_oe_o` low and `wave_o` low, and its waveform level holds through any match. When the channel is reconnected, `wave_o` shows the level held from before.
- R10: While `force_off_i` is high, all three channels are disconnected as in R9, whatever the output codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable |
| wave_mode_i | input | 4 | Waveform mode: counting sequence and TOP source |
| out_mode_a_i | input | 2 | Output code, channel A |
| out_mode_b_i | input | 2 | Output code, channel B |
| out_mode_c_i | input | 2 | Output code, channel C |
| cmp_a_i | input | W | Compare value A, also TOP in modes 4 and 15 |
| cmp_b_i | input | W | Compare value B |
| cmp_c_i | input | W | Compare value C |
| top_ext_i | input | W | TOP for mode 14 |
| force_off_i | input | 1 | Disconnect all channels |
| wave_o | output | 3 | Waveform pins {C, B, A}, low when disconnected |
| wave_oe_o | output | 3 | Drive enables {C, B, A} |
| ovf_o | output | 1 | Counter wrap strobe |
| match_o | output | 3 | Compare match strobes {C, B, A} |

## Verification
Two cases are hard to reach from the ports. The first is a compare value equal to TOP in fast PWM, where the match and the wrap-to-0 action fall on the same clock edge. The bench sets compare C, and in a second run compare B, exactly to TOP with the upper code bit set. It then checks the pin across two full periods, so a match that wins over the wrap action shows up as a wrong level. The second case is a channel that holds its level through a match that would have toggled it. The bench raises the force-off input just after a toggle and keeps it high across the next match. It then drops force-off and checks that the pin returns at the old level and that the following match toggles it as usual.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
  localparam int unsigned NUM_CH = 3;

  typedef enum logic [1:0] {
    WF_NORMAL = 2'd0,
    WF_CTC    = 2'd1,
    WF_FAST   = 2'd2
  } wave_kind_e;

  typedef enum logic [1:0] {
    TOP_MAX   = 2'd0,
    TOP_FIXED = 2'd1,
    TOP_CMPA  = 2'd2,
    TOP_EXT   = 2'd3
  } top_src_e;

  typedef struct packed {
    wave_kind_e kind;
    top_src_e   src;
    logic [1:0] fix_sel;      // fixed TOP = 2^(8+fix_sel)-1
    logic       toggle_a_ok;  // fast PWM toggle allowed on channel A
  } mode_cfg_t;

  localparam logic [1:0] OC_OFF = 2'b00;
  localparam logic [1:0] OC_TGL = 2'b01;
  localparam logic [1:0] OC_CLR = 2'b10;
  localparam logic [1:0] OC_SET = 2'b11;
endpackage

// File: rtl/cwt_mode_dec.sv
module cwt_mode_dec
  import cwt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [3:0]   wave_mode_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic [W-1:0] top_ext_i,
  output mode_cfg_t    cfg_o,
  output logic [W-1:0] top_o
);
  localparam logic [3:0] M_CTC   = 4'd4;
  localparam logic [3:0] M_F8    = 4'd5;
  localparam logic [3:0] M_F9    = 4'd6;
  localparam logic [3:0] M_F10   = 4'd7;
  localparam logic [3:0] M_FEXT  = 4'd14;
  localparam logic [3:0] M_FCMPA = 4'd15;
  localparam int unsigned FIX_BASE = 8;

  logic [W-1:0] fixed_top;

  always_comb begin
    cfg_o = '{kind: WF_NORMAL, src: TOP_MAX, fix_sel: 2'd0, toggle_a_ok: 1'b0};
    unique case (wave_mode_i)
      M_CTC:   cfg_o = '{kind: WF_CTC,  src: TOP_CMPA,  fix_sel: 2'd0, toggle_a_ok: 1'b0};
      M_F8:    cfg_o = '{kind: WF_FAST, src: TOP_FIXED, fix_sel: 2'd0, toggle_a_ok: 1'b0};
      M_F9:    cfg_o = '{kind: WF_FAST, src: TOP_FIXED, fix_sel: 2'd1, toggle_a_ok: 1'b0};
      M_F10:   cfg_o = '{kind: WF_FAST, src: TOP_FIXED, fix_sel: 2'd2, toggle_a_ok: 1'b0};
      M_FEXT:  cfg_o = '{kind: WF_FAST, src: TOP_EXT,   fix_sel: 2'd0, toggle_a_ok: 1'b1};
      M_FCMPA: cfg_o = '{kind: WF_FAST, src: TOP_CMPA,  fix_sel: 2'd0, toggle_a_ok: 1'b1};
      default: ;
    endcase
  end

  always_comb begin
    for (int i = 0; i < int'(W); i++) begin
      fixed_top[i] = (i < int'(FIX_BASE) + int'(cfg_o.fix_sel));
    end
  end

  always_comb begin
    unique case (cfg_o.src)
      TOP_FIXED: top_o = fixed_top;
      TOP_CMPA:  top_o = cmp_a_i;
      TOP_EXT:   top_o = top_ext_i;
      default:   top_o = '1;
    endcase
  end
endmodule

// File: rtl/cwt_counter.sv
module cwt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         at_top_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q;

  assign at_top_o = (cnt_q == top_i);
  assign cnt_o    = cnt_q;
  assign ovf_o    = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= en_i && at_top_o;
      if (en_i) cnt_q <= at_top_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cwt_channel.sv
module cwt_channel
  import cwt_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned CH_IDX = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         fast_i,
  input  logic         toggle_ok_i,
  input  logic [1:0]   out_mode_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] top_i,
  input  logic         at_top_i,
  input  logic         force_off_i,
  output logic         wave_o,
  output logic         oe_o,
  output logic         match_o,
  output logic         state_o
);
  localparam bit IS_A = (CH_IDX == 0);

  logic state_q, state_d, match_q, hit, bottom, cmp_is_top;

  assign hit        = en_i && (cnt_i == cmp_i);
  assign bottom     = en_i && at_top_i;
  assign cmp_is_top = (cmp_i == top_i);

  always_comb begin
    oe_o    = 1'b0;
    state_d = state_q;
    if (fast_i) begin
      unique case (out_mode_i)
        OC_TGL: begin
          if (IS_A && toggle_ok_i) begin
            oe_o = 1'b1;
            if (hit) state_d = ~state_q;
          end
        end
        OC_CLR, OC_SET: begin
          oe_o = 1'b1;
          // wrap action first; a match at TOP is dropped
          if (bottom)                  state_d = (out_mode_i == OC_CLR);
          else if (hit && !cmp_is_top) state_d = (out_mode_i == OC_SET);
        end
        default: ;
      endcase
    end else begin
      unique case (out_mode_i)
        OC_TGL: begin oe_o = 1'b1; if (hit) state_d = ~state_q; end
        OC_CLR: begin oe_o = 1'b1; if (hit) state_d = 1'b0;     end
        OC_SET: begin oe_o = 1'b1; if (hit) state_d = 1'b1;     end
        default: ;
      endcase
    end
    if (force_off_i) oe_o = 1'b0;
    if (!oe_o) state_d = state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      match_q <= 1'b0;
    end else begin
      state_q <= state_d;
      match_q <= hit;
    end
  end

  assign wave_o  = oe_o & state_q;
  assign match_o = match_q;
  assign state_o = state_q;
endmodule

// File: rtl/cwt_timer.sv
module cwt_timer
  import cwt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic [3:0]        wave_mode_i,
  input  logic [1:0]        out_mode_a_i,
  input  logic [1:0]        out_mode_b_i,
  input  logic [1:0]        out_mode_c_i,
  input  logic [W-1:0]      cmp_a_i,
  input  logic [W-1:0]      cmp_b_i,
  input  logic [W-1:0]      cmp_c_i,
  input  logic [W-1:0]      top_ext_i,
  input  logic              force_off_i,
  output logic [NUM_CH-1:0] wave_o,
  output logic [NUM_CH-1:0] wave_oe_o,
  output logic              ovf_o,
  output logic [NUM_CH-1:0] match_o
);
  mode_cfg_t          cfg;
  logic [W-1:0]       top_val;
  logic [W-1:0]       cnt_q;
  logic               at_top;
  logic [NUM_CH-1:0]  state_w;
  logic [W-1:0]       cmp_arr [NUM_CH];
  logic [1:0]         oc_arr  [NUM_CH];

  assign cmp_arr[0] = cmp_a_i;
  assign cmp_arr[1] = cmp_b_i;
  assign cmp_arr[2] = cmp_c_i;
  assign oc_arr[0]  = out_mode_a_i;
  assign oc_arr[1]  = out_mode_b_i;
  assign oc_arr[2]  = out_mode_c_i;

  cwt_mode_dec #(.W(W)) u_dec (
    .wave_mode_i (wave_mode_i),
    .cmp_a_i     (cmp_a_i),
    .top_ext_i   (top_ext_i),
    .cfg_o       (cfg),
    .top_o       (top_val)
  );

  cwt_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cnt_en_i),
    .top_i    (top_val),
    .cnt_o    (cnt_q),
    .at_top_o (at_top),
    .ovf_o    (ovf_o)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    cwt_channel #(.W(W), .CH_IDX(ch)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (cnt_en_i),
      .fast_i      (cfg.kind == WF_FAST),
      .toggle_ok_i (cfg.toggle_a_ok),
      .out_mode_i  (oc_arr[ch]),
      .cmp_i       (cmp_arr[ch]),
      .cnt_i       (cnt_q),
      .top_i       (top_val),
      .at_top_i    (at_top),
      .force_off_i (force_off_i),
      .wave_o      (wave_o[ch]),
      .oe_o        (wave_oe_o[ch]),
      .match_o     (match_o[ch]),
      .state_o     (state_w[ch])
    );
  end
endmodule

// File: rtl/cwt_timer_chk.sv
module cwt_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cnt_en_i,
  input logic [3:0]   wave_mode_i,
  input logic [1:0]   out_mode_a_i,
  input logic [1:0]   out_mode_b_i,
  input logic [1:0]   out_mode_c_i,
  input logic [W-1:0] cmp_a_i,
  input logic [W-1:0] cmp_c_i,
  input logic         force_off_i,
  input logic [2:0]   wave_o,
  input logic [2:0]   wave_oe_o,
  input logic         ovf_o,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] top_i,
  input logic [2:0]   state_i
);
  logic fast;
  assign fast = (wave_mode_i inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15});

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i && (cnt_i != top_i) |=> cnt_i == $past(cnt_i) + 1'b1); // R2
  AST_WRAP_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_i && (cnt_i == top_i) |=> (cnt_i == '0) && ovf_o); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_i |=> $stable(cnt_i) && !ovf_o && $stable(state_i)); // R2
  AST_BC_NO_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast && (out_mode_b_i == 2'b01) |-> !wave_oe_o[1]); // R7
  AST_NONINV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast && (out_mode_a_i == 2'b10) && cnt_en_i && (cnt_i == cmp_a_i)
      && (cmp_a_i != top_i) && !force_off_i |=> !state_i[0]); // R6
  AST_TOP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast && out_mode_c_i[1] && (cmp_c_i == top_i) && cnt_en_i && (cnt_i == top_i)
      && !force_off_i |=> state_i[2] == ($past(out_mode_c_i) == 2'b10)); // R8
  AST_DISC_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_o & ~wave_oe_o) == 3'b000); // R9
  AST_FORCE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |-> (wave_oe_o == 3'b000)); // R10
  AST_FORCE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> state_i == $past(state_i)); // R9
endmodule

bind cwt_timer cwt_timer_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_en_i     (cnt_en_i),
  .wave_mode_i  (wave_mode_i),
  .out_mode_a_i (out_mode_a_i),
  .out_mode_b_i (out_mode_b_i),
  .out_mode_c_i (out_mode_c_i),
  .cmp_a_i      (cmp_a_i),
  .cmp_c_i      (cmp_c_i),
  .force_off_i  (force_off_i),
  .wave_o       (wave_o),
  .wave_oe_o    (wave_oe_o),
  .ovf_o        (ovf_o),
  .cnt_i        (cnt_q),
  .top_i        (top_val),
  .state_i      (state_w)
);

// File: tb/cwt_timer_test.sv
module cwt_timer_test;
  localparam int W = 16;
  localparam int SEL_WAVE = 0;
  localparam int SEL_OE   = 1;
  localparam int SEL_OVF  = 2;
  localparam int SEL_MAT  = 3;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cnt_en_i = 1'b0;
  logic [3:0]   wave_mode_i = '0;
  logic [1:0]   out_mode_a_i = '0, out_mode_b_i = '0, out_mode_c_i = '0;
  logic [W-1:0] cmp_a_i = '0, cmp_b_i = '0, cmp_c_i = '0, top_ext_i = '0;
  logic         force_off_i = 1'b0;
  logic [2:0]   wave_o, wave_oe_o, match_o;
  logic         ovf_o;

  cwt_timer #(.W(W)) uut (.*);

  always #4 clk_i = ~clk_i;

  typedef struct {
    int         cyc;
    int         sel;
    logic [2:0] val;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int    ncyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  int    b;

  task automatic expect_at(input int cyc, input int sel, input logic [2:0] val, input string tag);
    item_t it;
    int pos;
    it.cyc = cyc; it.sel = sel; it.val = val; it.tag = tag;
    pos = exp_q.size();
    for (int i = 0; i < exp_q.size(); i++) begin
      if (exp_q[i].cyc > cyc) begin pos = i; break; end
    end
    exp_q.insert(pos, it);
  endtask

  function automatic logic [2:0] actual(input int sel);
    case (sel)
      SEL_WAVE: return wave_o;
      SEL_OE:   return wave_oe_o;
      SEL_OVF:  return {2'b00, ovf_o};
      default:  return match_o;
    endcase
  endfunction

  // monitor: pops scoreboard items due this cycle
  always @(negedge clk_i) begin
    ncyc = ncyc + 1;
    while (exp_q.size() > 0 && exp_q[0].cyc <= ncyc) begin
      item_t it;
      logic [2:0] a;
      it = exp_q.pop_front();
      n_chk++;
      a = actual(it.sel);
      if (it.cyc < ncyc) begin
        n_fail++;
        $display("FAIL %s: item for cycle %0d missed (now %0d) actual %b expected %b",
                 it.tag, it.cyc, ncyc, a, it.val);
      end else if (a !== it.val) begin
        n_fail++;
        $display("FAIL %s: cycle %0d sel %0d actual %b expected %b",
                 it.tag, ncyc, it.sel, a, it.val);
      end
    end
  end

  task automatic wait_cyc(input int c);
    while (ncyc < c) begin @(negedge clk_i); #1; end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) begin @(negedge clk_i); #1; end
  endtask

  task automatic do_reset();
    @(negedge clk_i); #1;
    rst_ni = 1'b0;
    cnt_en_i = 1'b0; force_off_i = 1'b0;
    wave_mode_i = '0; out_mode_a_i = '0; out_mode_b_i = '0; out_mode_c_i = '0;
    cmp_a_i = '0; cmp_b_i = '0; cmp_c_i = '0; top_ext_i = '0;
    @(negedge clk_i); #1;
    @(negedge clk_i); #1;
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    b = ncyc;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    expect_at(b + 1, SEL_WAVE, 3'b000, "R1 wave");
    expect_at(b + 1, SEL_OE,   3'b000, "R1 oe");
    expect_at(b + 1, SEL_OVF,  3'b000, "R1 ovf");
    expect_at(b + 1, SEL_MAT,  3'b000, "R1 match");
    drain();

    // CTC mode 4: A toggle, B clear, C set
    do_reset();
    wave_mode_i = 4'd4; cmp_a_i = 9; cmp_b_i = 3; cmp_c_i = 5;
    out_mode_a_i = 2'b01; out_mode_b_i = 2'b10; out_mode_c_i = 2'b11;
    cnt_en_i = 1'b1;
    expect_at(b + 1,  SEL_OE,   3'b111, "R5 oe ctc");
    expect_at(b + 4,  SEL_MAT,  3'b010, "R4 match B");
    expect_at(b + 5,  SEL_MAT,  3'b000, "R4 match one cycle");
    expect_at(b + 5,  SEL_WAVE, 3'b000, "R4 C before match");
    expect_at(b + 6,  SEL_WAVE, 3'b100, "R5 set on match");
    expect_at(b + 6,  SEL_MAT,  3'b100, "R4 match C");
    expect_at(b + 9,  SEL_WAVE, 3'b100, "R5 before toggle");
    expect_at(b + 9,  SEL_OVF,  3'b000, "R2 no ovf before top");
    expect_at(b + 10, SEL_WAVE, 3'b101, "R5 toggle");
    expect_at(b + 10, SEL_MAT,  3'b001, "R4 match A");
    expect_at(b + 10, SEL_OVF,  3'b001, "R3 ctc top=cmp_a");
    expect_at(b + 11, SEL_OVF,  3'b000, "R2 ovf one cycle");
    expect_at(b + 20, SEL_WAVE, 3'b100, "R5 toggle back");
    drain();

    // mode 9 acts as normal: TOP 0xFFFF; code 00 disconnects
    do_reset();
    wave_mode_i = 4'd9; cmp_a_i = 100; cmp_b_i = 500; cmp_c_i = 500;
    out_mode_a_i = 2'b11;
    cnt_en_i = 1'b1;
    expect_at(b + 1,     SEL_OE,   3'b001, "R5 code 00 disconnects");
    expect_at(b + 100,   SEL_WAVE, 3'b000, "R5 before set");
    expect_at(b + 101,   SEL_WAVE, 3'b001, "R5 set normal");
    expect_at(b + 65535, SEL_OVF,  3'b000, "R3 no early wrap");
    expect_at(b + 65536, SEL_OVF,  3'b001, "R3 wrap at 0xFFFF");
    drain();

    // fast PWM mode 5, TOP 0xFF; C compare at TOP
    do_reset();
    wave_mode_i = 4'd5; cmp_a_i = 50; cmp_b_i = 100; cmp_c_i = 255;
    out_mode_a_i = 2'b10; out_mode_b_i = 2'b11; out_mode_c_i = 2'b10;
    cnt_en_i = 1'b1;
    expect_at(b + 1,   SEL_OE,   3'b111, "R6 oe fast");
    expect_at(b + 50,  SEL_WAVE, 3'b000, "R6 idle");
    expect_at(b + 101, SEL_WAVE, 3'b010, "R6 inverting set on match");
    expect_at(b + 256, SEL_OVF,  3'b001, "R3 fixed top 0xFF");
    expect_at(b + 256, SEL_WAVE, 3'b101, "R8 bottom action only");
    expect_at(b + 307, SEL_WAVE, 3'b100, "R6 non-inverting clear on match");
    expect_at(b + 357, SEL_WAVE, 3'b110, "R6 inverting set again");
    expect_at(b + 512, SEL_WAVE, 3'b101, "R8 match at top ignored");
    drain();

    // fast PWM mode 15: toggle A only
    do_reset();
    wave_mode_i = 4'd15; cmp_a_i = 19; cmp_b_i = 4; cmp_c_i = 4;
    out_mode_a_i = 2'b01; out_mode_b_i = 2'b01; out_mode_c_i = 2'b01;
    cnt_en_i = 1'b1;
    expect_at(b + 1,  SEL_OE,   3'b001, "R7 only A driven");
    expect_at(b + 19, SEL_WAVE, 3'b000, "R7 before toggle");
    expect_at(b + 20, SEL_WAVE, 3'b001, "R7 toggle A");
    expect_at(b + 20, SEL_OVF,  3'b001, "R3 top=cmp_a fast");
    expect_at(b + 40, SEL_WAVE, 3'b000, "R7 toggle A back");
    drain();

    // fast PWM mode 7 with code 01: all disconnected; TOP 0x3FF
    do_reset();
    wave_mode_i = 4'd7; cmp_a_i = 3; cmp_b_i = 3; cmp_c_i = 3;
    out_mode_a_i = 2'b01; out_mode_b_i = 2'b01; out_mode_c_i = 2'b01;
    cnt_en_i = 1'b1;
    expect_at(b + 1,    SEL_OE,   3'b000, "R7 code 01 disconnects all");
    expect_at(b + 5,    SEL_WAVE, 3'b000, "R7 pins low");
    expect_at(b + 1024, SEL_OVF,  3'b001, "R3 fixed top 0x3FF");
    drain();

    // fast PWM mode 14, external TOP; B compare at TOP inverting
    do_reset();
    wave_mode_i = 4'd14; top_ext_i = 29; cmp_a_i = 10; cmp_b_i = 29; cmp_c_i = 500;
    out_mode_a_i = 2'b10; out_mode_b_i = 2'b11;
    cnt_en_i = 1'b1;
    expect_at(b + 30, SEL_OVF,  3'b001, "R3 top=ext");
    expect_at(b + 30, SEL_WAVE, 3'b001, "R8 inverting at top: clear only");
    expect_at(b + 41, SEL_WAVE, 3'b000, "R6 non-inverting clear");
    expect_at(b + 60, SEL_WAVE, 3'b001, "R8 second period");
    drain();

    // force-off across a toggle match, then resume
    do_reset();
    wave_mode_i = 4'd4; cmp_a_i = 9; cmp_b_i = 500; cmp_c_i = 500;
    out_mode_a_i = 2'b01;
    cnt_en_i = 1'b1;
    expect_at(b + 10, SEL_WAVE, 3'b001, "R9 level before off");
    expect_at(b + 11, SEL_OE,   3'b000, "R10 force off");
    expect_at(b + 11, SEL_WAVE, 3'b000, "R9 disconnected pin low");
    expect_at(b + 25, SEL_OE,   3'b000, "R10 still off");
    expect_at(b + 26, SEL_OE,   3'b001, "R9 reconnect");
    expect_at(b + 26, SEL_WAVE, 3'b001, "R9 level held through match");
    expect_at(b + 30, SEL_WAVE, 3'b000, "R9 toggles after resume");
    wait_cyc(b + 10);
    force_off_i = 1'b1;
    wait_cyc(b + 25);
    force_off_i = 1'b0;
    drain();

    // count enable pause
    do_reset();
    wave_mode_i = 4'd4; cmp_a_i = 9; cmp_b_i = 500; cmp_c_i = 500;
    out_mode_a_i = 2'b01;
    cnt_en_i = 1'b1;
    expect_at(b + 12, SEL_OVF,  3'b000, "R2 no ovf while paused");
    expect_at(b + 15, SEL_MAT,  3'b000, "R2 no match while paused");
    expect_at(b + 29, SEL_WAVE, 3'b000, "R2 pause delays match");
    expect_at(b + 30, SEL_WAVE, 3'b001, "R2 match after resume");
    wait_cyc(b + 5);
    cnt_en_i = 1'b0;
    wait_cyc(b + 25);
    cnt_en_i = 1'b1;
    drain();

    summary();
    $finish;
  end
endmodule